// File: doc/BRIEF.md
# Pointer-Addressed Register Window with Auto-Advance

This block gives a host a two-location register window onto a larger bank of byte-wide registers. One location is a pointer: it holds the address of the bank word to reach and an enable for automatic advance. The other location is a data port. Each read or write through the data port acts on the word the pointer names. After that access, the pointer moves to the next address if the advance enable is set, so a host can stream through a run of consecutive words after setting the pointer only once.

The bank has 57 populated words. Words 0 to 7 are read-only. They show a live 64-bit received time-code frame, with frame bit 0 in bit 0 of word 0 and frame bit 63 in bit 7 of word 7. Words 8 to 15 are writable and together drive a 64-bit transmit frame output, with frame bit 0 in bit 0 of word 8 and frame bit 63 in bit 7 of word 15. Words 16 to 56 are plain read/write storage. Addresses 57 to 63 are unpopulated.

Host reads return their data on the cycle after the read strobe, and the value is held until the next read.

Top module: `ireg_port`

## Requirements
- R1: After reset, the pointer address is 0, advance is off, every writable word is 0, `tx_frame` is 0 and `host_rdata` is 0.
- R2: A write with `host_sel`=0 loads the address from `host_wdata[5:0]` and the advance enable from `host_wdata[7]`. A read with `host_sel`=0 returns {advance, 0, address}, so bit 6 always reads 0.
- R3: With advance enabled, each data-port access (`host_sel`=1 with read, write, or both) raises the address by exactly one on the following cycle.
- R4: With advance disabled, data-port accesses leave the address unchanged.
- R5: An advance from address 63 wraps the address to 0.
- R6: A data read at address k, for k from 0 to 7, returns `rx_frame[8k+7:8k]` as sampled in the cycle of the read strobe.
- R7: Data writes to addresses 0 to 7 change no stored state: `tx_frame` stays the same, and those addresses still read back the received frame.
- R8: A data write to address k, for k from 8 to 15, sets `tx_frame[8(k-8)+7:8(k-8)]` to the written byte from the next cycle on, and that byte reads back at address k.
- R9: Addresses 16 to 56 store any byte written to them and return it on later reads.
- R10: Addresses 57 to 63 always read 0, and writes to them are ignored.
- R11: Read data appears on `host_rdata` one cycle after the read strobe and stays unchanged in every cycle without a read strobe.
- R12: A read and a write on the data port in the same cycle return the word's value from before the write, perform the write, and advance the pointer only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | 0 selects the pointer, 1 selects the data port |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| rx_frame | input | 64 | Received time-code frame, shown at words 0 to 7 |
| tx_frame | output | 64 | Transmit frame, driven by words 8 to 15 |

## Verification
The embedded assertions check on every cycle the rules that involve only one or two adjacent cycles: the pointer step or hold after each data access, the wrap at 63, the zero in bit 6 of a pointer read, zero reads above the populated range, a stable `tx_frame` after writes to read-only words, the update of the addressed transmit byte, and the holding of read data between strobes. Only the bench's scenarios can show the longer-range behaviour. Those scenarios cover streaming whole frames in and out through one pointer setting, storage that keeps its values across many later accesses, and read-only words that still show the received frame after a write sweep. They also cover a simultaneous read and write returning the old value.

// File: rtl/ireg_pkg.sv
package ireg_pkg;

   // kind of storage behind each address slot
   typedef enum logic [1:0] {
      SLOT_CAPTURE = 2'd0,
      SLOT_TRANSMIT = 2'd1,
      SLOT_PLAIN = 2'd2,
      SLOT_EMPTY = 2'd3
   } slot_kind_e;

   function automatic slot_kind_e slot_kind(input int idx, input int rx_words,
                                            input int tx_words, input int num_regs);
      if (idx < rx_words) return SLOT_CAPTURE;
      if (idx < rx_words + tx_words) return SLOT_TRANSMIT;
      if (idx < num_regs) return SLOT_PLAIN;
      return SLOT_EMPTY;
   endfunction

endpackage

// File: rtl/ireg_pointer.sv
module ireg_pointer #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              data_access,
   output logic [ADDR_W-1:0] addr,
   output logic              adv_en,
   output logic [DATA_W-1:0] ptr_view
);
   localparam int ADV_BIT = DATA_W - 1;
   localparam int PAD_W = DATA_W - ADDR_W - 1;

   generate
      if (PAD_W < 1) begin : g_bad_width
         $error("ireg_pointer: DATA_W must leave a spare bit between address and advance bit");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         adv_en <= 1'b0;
      end else if (ptr_load) begin
         addr   <= load_val[ADDR_W-1:0];
         adv_en <= load_val[ADV_BIT];
      end else if (data_access && adv_en) begin
         addr <= addr + 1'b1;
      end
   end

   assign ptr_view = {adv_en, {PAD_W{1'b0}}, addr};

   a_r3_step_after_access: assert property (@(posedge clk) disable iff (!rst_n)
      (data_access && adv_en && !ptr_load) |=> (addr == $past(addr) + 1'b1));

   a_r4_hold_without_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (data_access && !adv_en && !ptr_load) |=> $stable(addr));

   a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (data_access && adv_en && !ptr_load && (addr == {ADDR_W{1'b1}})) |=> (addr == '0));

endmodule

// File: rtl/ireg_bank.sv
module ireg_bank
   import ireg_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6,
   parameter int RX_WORDS = 8,
   parameter int TX_WORDS = 8,
   parameter int NUM_REGS = 57
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_word,
   input  logic [RX_WORDS*DATA_W-1:0]   rx_frame,
   output logic [TX_WORDS*DATA_W-1:0]   tx_frame
);
   localparam int SPAN = 1 << ADDR_W;
   localparam int TX_BASE = RX_WORDS;

   generate
      if (NUM_REGS > SPAN) begin : g_bad_count
         $error("ireg_bank: NUM_REGS exceeds the address span");
      end
      if (RX_WORDS + TX_WORDS > NUM_REGS) begin : g_bad_split
         $error("ireg_bank: capture and transmit words exceed NUM_REGS");
      end
   endgenerate

   logic [SPAN-1:0][DATA_W-1:0] word_view;

   genvar gi;
   generate
      for (gi = 0; gi < SPAN; gi++) begin : g_slot
         localparam slot_kind_e KIND = slot_kind(gi, RX_WORDS, TX_WORDS, NUM_REGS);
         if (KIND == SLOT_CAPTURE) begin : g_capture
            assign word_view[gi] = rx_frame[gi*DATA_W +: DATA_W];
         end else if (KIND == SLOT_EMPTY) begin : g_empty
            assign word_view[gi] = '0;
         end else begin : g_stored
            logic [DATA_W-1:0] word_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) word_q <= '0;
               else if (wr_en && (wr_addr == ADDR_W'(gi))) word_q <= wr_data;
            end
            assign word_view[gi] = word_q;
         end
      end

      for (gi = 0; gi < TX_WORDS; gi++) begin : g_tx_out
         assign tx_frame[gi*DATA_W +: DATA_W] = word_view[TX_BASE + gi];
      end
   endgenerate

   assign rd_word = word_view[rd_addr];

   a_r7_capture_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ({1'b0, wr_addr} < (ADDR_W+1)'(RX_WORDS))) |=> $stable(tx_frame));

   a_r8_transmit_byte_updates: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ({1'b0, wr_addr} >= (ADDR_W+1)'(TX_BASE))
             && ({1'b0, wr_addr} < (ADDR_W+1)'(TX_BASE + TX_WORDS)))
      |=> (tx_frame[(int'($past(wr_addr)) - TX_BASE)*DATA_W +: DATA_W] == $past(wr_data)));

endmodule

// File: rtl/ireg_port.sv
module ireg_port #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 6,
   parameter int RX_WORDS = 8,
   parameter int TX_WORDS = 8,
   parameter int NUM_REGS = 57
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_sel,
   input  logic                       host_wr,
   input  logic                       host_rd,
   input  logic [DATA_W-1:0]          host_wdata,
   output logic [DATA_W-1:0]          host_rdata,
   input  logic [RX_WORDS*DATA_W-1:0] rx_frame,
   output logic [TX_WORDS*DATA_W-1:0] tx_frame
);
   logic              ptr_load;
   logic              data_access;
   logic [ADDR_W-1:0] cur_addr;
   logic              adv_en;
   logic [DATA_W-1:0] ptr_view;
   logic [DATA_W-1:0] bank_word;

   assign ptr_load    = host_wr && !host_sel;
   assign data_access = host_sel && (host_rd || host_wr);

   ireg_pointer #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_pointer (
      .clk         (clk),
      .rst_n       (rst_n),
      .ptr_load    (ptr_load),
      .load_val    (host_wdata),
      .data_access (data_access),
      .addr        (cur_addr),
      .adv_en      (adv_en),
      .ptr_view    (ptr_view)
   );

   ireg_bank #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .RX_WORDS (RX_WORDS),
      .TX_WORDS (TX_WORDS),
      .NUM_REGS (NUM_REGS)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (host_wr && host_sel),
      .wr_addr  (cur_addr),
      .wr_data  (host_wdata),
      .rd_addr  (cur_addr),
      .rd_word  (bank_word),
      .rx_frame (rx_frame),
      .tx_frame (tx_frame)
   );

   // read data is registered; the old word is captured even when written in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) host_rdata <= '0;
      else if (host_rd) host_rdata <= host_sel ? bank_word : ptr_view;
   end

   a_r2_spare_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_sel) |=> (host_rdata[DATA_W-2:ADDR_W] == '0));

   a_r10_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_sel && ({1'b0, cur_addr} >= (ADDR_W+1)'(NUM_REGS))) |=> (host_rdata == '0));

   a_r11_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> $stable(host_rdata));

endmodule

// File: tb/ireg_port_test.sv
module ireg_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic [63:0] rx_frame = 64'h0;
   logic [63:0] tx_frame;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   ireg_port uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_sel   (host_sel),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .rx_frame   (rx_frame),
      .tx_frame   (tx_frame)
   );

   // reference model built from the requirements
   logic [7:0] m_word [64];
   logic [5:0] m_addr;
   logic       m_adv;

   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic       rd_seen = 1'b0;

   task automatic check(input logic [63:0] got, input logic [63:0] exp, input string tag);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] model_read(input logic [5:0] a);
      if (a < 8) return rx_frame[a*8 +: 8];
      if (a < 57) return m_word[a];
      return 8'h00;
   endfunction

   function automatic logic [63:0] model_tx();
      logic [63:0] v;
      for (int k = 0; k < 8; k++) v[k*8 +: 8] = m_word[8+k];
      return v;
   endfunction

   // driver: one bus cycle, expected read data goes to the scoreboard queue
   task automatic bus(input bit sel, input bit rd, input bit wr, input logic [7:0] d,
                      input string tag);
      @(negedge clk);
      host_sel = sel; host_rd = rd; host_wr = wr; host_wdata = d;
      if (rd) begin
         exp_q.push_back(sel ? model_read(m_addr) : {m_adv, 1'b0, m_addr});
         tag_q.push_back(tag);
      end
      if (!sel && wr) begin
         m_addr = d[5:0];
         m_adv  = d[7];
      end else if (sel) begin
         if (wr && m_addr >= 8 && m_addr < 57) m_word[m_addr] = d;
         if (m_adv) m_addr = m_addr + 6'd1;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         host_rd = 1'b0; host_wr = 1'b0;
      end
   endtask

   // monitor: compares each read result one cycle after its strobe
   always @(posedge clk) rd_seen <= host_rd;
   always @(negedge clk) begin
      if (rd_seen && rst_n) begin
         if (exp_q.size() == 0) check(1, 0, "scoreboard underflow");
         else check(host_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stimulus
      logic [7:0] held;
      for (int i = 0; i < 64; i++) m_word[i] = 8'h00;
      m_addr = '0; m_adv = 1'b0;
      rx_frame = 64'hF0E1_D2C3_B4A5_9687;
      repeat (3) @(negedge clk);
      check(host_rdata, 8'h00, "R1 rdata after reset");
      check(tx_frame, 64'h0, "R1 tx_frame after reset");
      rst_n = 1'b1;
      bus(0, 1, 0, 8'h00, "R1 pointer after reset");
      // R2 pointer fields, bit 6 reads zero
      bus(0, 0, 1, 8'hFF, "R2");
      bus(0, 1, 0, 8'h00, "R2 pointer readback bit6 zero");
      bus(0, 0, 1, 8'h05, "R2");
      bus(0, 1, 0, 8'h00, "R2 pointer readback no advance");
      // R6 / R3 stream received frame with advance
      bus(0, 0, 1, 8'h80, "R3");
      for (int k = 0; k < 8; k++) bus(1, 1, 0, 8'h00, "R6 capture word");
      bus(0, 1, 0, 8'h00, "R3 pointer after eight reads");
      // R8 write transmit words
      for (int k = 0; k < 8; k++) bus(1, 0, 1, 8'h11 * (k + 1), "R8");
      idle(1);
      check(tx_frame, model_tx(), "R8 tx_frame after writes");
      bus(0, 0, 1, 8'h88, "R8");
      for (int k = 0; k < 8; k++) bus(1, 1, 0, 8'h00, "R8 transmit readback");
      // R7 writes to capture words ignored
      bus(0, 0, 1, 8'h80, "R7");
      for (int k = 0; k < 8; k++) bus(1, 0, 1, 8'h5A, "R7");
      idle(1);
      check(tx_frame, model_tx(), "R7 tx_frame unchanged");
      rx_frame = 64'h0123_4567_89AB_CDEF;
      bus(0, 0, 1, 8'h80, "R7");
      for (int k = 0; k < 8; k++) bus(1, 1, 0, 8'h00, "R7 capture still shows rx");
      // R9 plain storage
      bus(0, 0, 1, 8'h90, "R9");
      for (int a = 16; a < 57; a++) bus(1, 0, 1, 8'(a * 7 + 3), "R9");
      // R10 empty slots, then R5 wrap
      for (int a = 57; a < 64; a++) bus(1, 0, 1, 8'hFF, "R10");
      bus(0, 1, 0, 8'h00, "R5 pointer wrapped to 0");
      bus(0, 0, 1, 8'hB9, "R10");
      for (int a = 57; a < 64; a++) bus(1, 1, 0, 8'h00, "R10 empty reads zero");
      bus(0, 1, 0, 8'h00, "R5 wrap after reads");
      bus(0, 0, 1, 8'h90, "R9");
      for (int a = 16; a < 57; a++) bus(1, 1, 0, 8'h00, "R9 storage readback");
      // R4 hold address
      bus(0, 0, 1, 8'h14, "R4");
      bus(1, 0, 1, 8'h3C, "R4");
      bus(1, 0, 1, 8'h4D, "R4");
      bus(0, 1, 0, 8'h00, "R4 pointer held");
      bus(1, 1, 0, 8'h00, "R4 last write landed");
      // R11 hold between strobes
      idle(1);
      held = host_rdata;
      idle(4);
      check(host_rdata, held, "R11 rdata held");
      check(host_rdata, 8'h4D, "R11 rdata value");
      // R12 simultaneous read and write
      bus(0, 0, 1, 8'h94, "R12");
      bus(1, 1, 1, 8'hE7, "R12 old value returned");
      bus(0, 1, 0, 8'h00, "R12 single advance");
      bus(0, 0, 1, 8'h14, "R12");
      bus(1, 1, 0, 8'h00, "R12 write landed");
      idle(3);
      check(exp_q.size(), 0, "scoreboard drained");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule